// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects level-sensitive interrupt requests from up to `NUM_VEC` numbered sources and picks one vector to offer a processor core. Eight low-numbered core exceptions run at hard-wired levels. Every other source gets a two-bit programmable priority, and one of its codes means "disabled". The core reports the level it is currently running at. The controller offers only requests that this level accepts for nesting. Among those, it offers the one with the highest level and, within a level, the lowest vector number.

Two fast slots can each name a maskable vector. That vector is then promoted above every other level-2 request, and its handler address comes from the slot instead of the vector table. The offer to the core is registered. A request/acknowledge pair hands the vector over, and the acknowledge records the taken vector in a read-only register. A small synchronous register port gives access to the priority fields, the table base, the fast slots, the last vector taken and a pending bitmap.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Priority register k (address k) holds the 2-bit field of vector 8k+j in bits [2j+1:2j]. The codes are 00 disabled, 01 level 0, 10 level 1 and 11 level 2. All fields are 00 after reset. Fields of vectors 0..9 read 0 and ignore writes.
- R2: Vectors 2..5 run at level 3, vector 6 at level 2, vector 7 at level 1, vector 8 at level 0 and vector 9 at the low-priority level below level 0. These vectors are always enabled.
- R3: `core_lvl` is coded 0 none, 1 low-priority active, and 2..5 for levels 0..3. Rank the requests as low-priority 0 and levels 0..3 as 1..4. A request is accepted only if its rank is at least min(`core_lvl`, 4).
- R4: Among accepted pending requests, the higher rank wins, and at equal rank the lower vector number wins.
- R5: An enabled maskable vector named in fast slot 0 or 1 ranks as level 2 and beats every other level-2 request. Slot 0 beats slot 1. Its `irq_addr` is the 21-bit slot address.
- R6: The winner appears on `irq_req`/`irq_vec`/`irq_lvl`/`irq_addr` at the second clock edge after its request is raised. `irq_lvl` uses the same code as `core_lvl`. For a vector that is not in a fast slot, `irq_addr` = base*256 + 2*vector.
- R7: An edge with `irq_ack` and `irq_req` both high stores `irq_vec` as the last vector and drops `irq_req` for one cycle. At every other edge the last vector is unchanged.
- R8: A request sets its pending bit, which stays set after the request falls. Pending register address 0x20+k, bit i, is vector 2+16k+i. An acknowledge of that vector clears the bit only if its request is low at that edge.
- R9: The vector base at 0x10 holds 13 bits in [12:0]. Bits [15:13] read 0.
- R10: Fast slot s uses address 0x11+3s for the vector [6:0], 0x12+3s for address bits [20:16] and 0x13+3s for address bits [15:0]. The last vector reads at 0x18. Read data appears one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_VEC | Level request per vector number |
| core_lvl | input | 3 | Current core level code |
| irq_ack | input | 1 | Core takes the offered vector |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| irq_req | output | 1 | Interrupt offered to the core |
| irq_lvl | output | 3 | Level code of the offered interrupt |
| irq_vec | output | 7 | Offered vector number |
| irq_addr | output | 21 | Handler address of the offered vector |

## Verification
The properties assume that the core raises `irq_ack` only as a single-cycle pulse, and that `core_lvl` never carries codes 6 or 7. The bench drives acknowledges as one-cycle pulses, and only while `irq_req` is high. It draws core levels from 0..5 only. It also keeps each request pattern steady from the moment it is applied until the acknowledge, so that every drop of a request lands on a known edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int VEC_W   = 7;
  localparam int ADDR_W  = 21;
  localparam int DATA_W  = 16;
  localparam int RA_W    = 6;
  localparam int BASE_W  = ADDR_W - 8;
  localparam int HI_W    = ADDR_W - DATA_W;
  localparam int FIX_LO  = 2;   // first interrupt vector
  localparam int MASK_LO = 10;  // first programmable vector
  localparam int FLD_PER_REG  = 8;
  localparam int PEND_PER_REG = 16;

  localparam logic [RA_W-1:0] RA_VBASE  = 6'h10;
  localparam logic [RA_W-1:0] RA_F0_VEC = 6'h11;
  localparam logic [RA_W-1:0] RA_F0_HI  = 6'h12;
  localparam logic [RA_W-1:0] RA_F0_LO  = 6'h13;
  localparam logic [RA_W-1:0] RA_F1_VEC = 6'h14;
  localparam logic [RA_W-1:0] RA_F1_HI  = 6'h15;
  localparam logic [RA_W-1:0] RA_F1_LO  = 6'h16;
  localparam logic [RA_W-1:0] RA_LAST   = 6'h18;
  localparam logic [RA_W-1:0] RA_PEND   = 6'h20;

  // rank: 0 low-priority software, 1..4 levels 0..3
  typedef logic [2:0] rank_t;

  typedef struct packed {
    logic [VEC_W-1:0]  vec;
    logic [HI_W-1:0]   hi;
    logic [DATA_W-1:0] lo;
  } fast_slot_t;

  function automatic rank_t fixed_rank(input logic [VEC_W-1:0] v);
    case (v)
      7'd6:    return 3'd3;
      7'd7:    return 3'd2;
      7'd8:    return 3'd1;
      7'd9:    return 3'd0;
      default: return 3'd4;
    endcase
  endfunction

  function automatic rank_t accept_floor(input logic [2:0] core);
    return (core > 3'd4) ? 3'd4 : core;
  endfunction

  function automatic logic [ADDR_W-1:0] table_addr(input logic [BASE_W-1:0] base,
                                                    input logic [VEC_W-1:0] v);
    return {base, 8'h00} + ADDR_W'({v, 1'b0});
  endfunction
endpackage

// File: rtl/irq_prio_pend.sv
module irq_prio_pend
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 82
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] src_req,
  input  logic               clr_en,
  input  logic [VEC_W-1:0]   clr_vec,
  output logic [NUM_VEC-1:0] pend
);
  logic unused_low;
  assign unused_low = ^src_req[FIX_LO-1:0];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_bit
    if (v < FIX_LO) begin : g_none
      assign pend[v] = 1'b0;
    end else begin : g_src
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= src_req[v] | (bit_q & ~(clr_en && clr_vec == VEC_W'(v)));
      end
      assign pend[v] = bit_q;
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 82
) (
  input  logic [NUM_VEC-1:0]   pend,
  input  logic [2*NUM_VEC-1:0] prio,
  input  logic [VEC_W-1:0]     fast0_vec,
  input  logic [VEC_W-1:0]     fast1_vec,
  input  logic [2:0]           core_lvl,
  output logic                 win_valid,
  output logic [VEC_W-1:0]     win_vec,
  output rank_t                win_rank,
  output logic [1:0]           win_fast
);
  rank_t floor_r;
  assign floor_r = accept_floor(core_lvl);

  logic unused_low;
  assign unused_low = ^{pend[FIX_LO-1:0], prio[2*FIX_LO-1:0]};

  logic       en;
  rank_t      r;
  logic [1:0] fb;
  logic [1:0] code;

  always_comb begin
    win_valid = 1'b0;
    win_vec   = '0;
    win_rank  = '0;
    win_fast  = '0;
    en = 1'b0; r = '0; fb = '0; code = '0;
    for (int v = FIX_LO; v < NUM_VEC; v++) begin
      code = prio[2*v +: 2];
      fb   = 2'b00;
      if (v < MASK_LO) begin
        en = 1'b1;
        r  = fixed_rank(VEC_W'(v));
      end else begin
        en = (code != 2'b00);
        r  = rank_t'(code);
        if (en && fast0_vec == VEC_W'(v)) begin
          r = 3'd3; fb = 2'b10;
        end else if (en && fast1_vec == VEC_W'(v)) begin
          r = 3'd3; fb = 2'b01;
        end
      end
      if (pend[v] && en && r >= floor_r &&
          (!win_valid || r > win_rank || (r == win_rank && fb > win_fast))) begin
        win_valid = 1'b1;
        win_vec   = VEC_W'(v);
        win_rank  = r;
        win_fast  = fb;
      end
    end
  end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 82
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RA_W-1:0]      addr,
  input  logic                 wr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_VEC-1:0]   pend,
  input  logic                 take,
  input  logic [VEC_W-1:0]     take_vec,
  output logic [2*NUM_VEC-1:0] prio,
  output logic [BASE_W-1:0]    vbase,
  output fast_slot_t           fast0,
  output fast_slot_t           fast1,
  output logic [VEC_W-1:0]     last_vec
);
  localparam int PRIO_REGS = (NUM_VEC + FLD_PER_REG - 1) / FLD_PER_REG;
  localparam int PEND_REGS = (NUM_VEC - FIX_LO + PEND_PER_REG - 1) / PEND_PER_REG;

  logic [2*NUM_VEC-1:0] prio_q;
  logic [DATA_W-1:0]    rd_n;
  int                   idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (wr) begin
      for (int v = MASK_LO; v < NUM_VEC; v++)
        if (addr == RA_W'(v / FLD_PER_REG))
          prio_q[2*v +: 2] <= wdata[2*(v % FLD_PER_REG) +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbase    <= '0;
      fast0    <= '0;
      fast1    <= '0;
      last_vec <= '0;
    end else begin
      if (take) last_vec <= take_vec;
      if (wr) begin
        case (addr)
          RA_VBASE:  vbase    <= wdata[BASE_W-1:0];
          RA_F0_VEC: fast0.vec <= wdata[VEC_W-1:0];
          RA_F0_HI:  fast0.hi  <= wdata[HI_W-1:0];
          RA_F0_LO:  fast0.lo  <= wdata;
          RA_F1_VEC: fast1.vec <= wdata[VEC_W-1:0];
          RA_F1_HI:  fast1.hi  <= wdata[HI_W-1:0];
          RA_F1_LO:  fast1.lo  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_n = '0;
    idx  = 0;
    if (int'(addr) < PRIO_REGS) begin
      for (int j = 0; j < FLD_PER_REG; j++) begin
        idx = int'(addr) * FLD_PER_REG + j;
        if (idx < NUM_VEC) rd_n[2*j +: 2] = prio_q[2*idx +: 2];
      end
    end else if (addr >= RA_PEND && int'(addr) < int'(RA_PEND) + PEND_REGS) begin
      for (int i = 0; i < PEND_PER_REG; i++) begin
        idx = FIX_LO + PEND_PER_REG * (int'(addr) - int'(RA_PEND)) + i;
        if (idx < NUM_VEC) rd_n[i] = pend[idx];
      end
    end else begin
      case (addr)
        RA_VBASE:  rd_n[BASE_W-1:0] = vbase;
        RA_F0_VEC: rd_n[VEC_W-1:0]  = fast0.vec;
        RA_F0_HI:  rd_n[HI_W-1:0]   = fast0.hi;
        RA_F0_LO:  rd_n             = fast0.lo;
        RA_F1_VEC: rd_n[VEC_W-1:0]  = fast1.vec;
        RA_F1_HI:  rd_n[HI_W-1:0]   = fast1.hi;
        RA_F1_LO:  rd_n             = fast1.lo;
        RA_LAST:   rd_n[VEC_W-1:0]  = last_vec;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_n;
  end

  assign prio = prio_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 82
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] src_req,
  input  logic [2:0]         core_lvl,
  input  logic               irq_ack,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_req,
  output logic [2:0]         irq_lvl,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [ADDR_W-1:0]  irq_addr
);
  logic [NUM_VEC-1:0]   pend;
  logic [2*NUM_VEC-1:0] prio;
  logic [BASE_W-1:0]    vbase;
  fast_slot_t           fast0, fast1;
  logic [VEC_W-1:0]     last_vec;
  logic                 win_valid;
  logic [VEC_W-1:0]     win_vec;
  rank_t                win_rank;
  logic [1:0]           win_fast;
  logic [ADDR_W-1:0]    win_addr;
  logic                 take;

  assign take = irq_ack & irq_req;

  irq_prio_pend #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .clr_en(take), .clr_vec(irq_vec), .pend(pend)
  );

  irq_prio_regs #(.NUM_VEC(NUM_VEC)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .pend(pend), .take(take), .take_vec(irq_vec),
    .prio(prio), .vbase(vbase), .fast0(fast0), .fast1(fast1), .last_vec(last_vec)
  );

  irq_prio_arb #(.NUM_VEC(NUM_VEC)) u_arb (
    .pend(pend), .prio(prio), .fast0_vec(fast0.vec), .fast1_vec(fast1.vec),
    .core_lvl(core_lvl), .win_valid(win_valid), .win_vec(win_vec),
    .win_rank(win_rank), .win_fast(win_fast)
  );

  always_comb begin
    case (win_fast)
      2'b10:   win_addr = {fast0.hi, fast0.lo};
      2'b01:   win_addr = {fast1.hi, fast1.lo};
      default: win_addr = table_addr(vbase, win_vec);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req  <= 1'b0;
      irq_lvl  <= '0;
      irq_vec  <= '0;
      irq_addr <= '0;
    end else if (take) begin
      irq_req <= 1'b0;
      irq_lvl <= '0;
    end else begin
      irq_req  <= win_valid;
      irq_lvl  <= win_valid ? 3'(win_rank + 3'd1) : 3'd0;
      irq_vec  <= win_vec;
      irq_addr <= win_addr;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 82
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        core_lvl,
  input logic              irq_req,
  input logic [2:0]        irq_lvl,
  input logic [VEC_W-1:0]  irq_vec,
  input logic [RA_W-1:0]   reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              take,
  input logic [VEC_W-1:0]  last_vec
);
  assert_accept_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl >= 3'(accept_floor($past(core_lvl)) + 3'd1)));

  assert_vec_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= VEC_W'(FIX_LO) && int'(irq_vec) < NUM_VEC));

  assert_last_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (last_vec == $past(irq_vec)));

  assert_last_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(last_vec));

  assert_drop_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !irq_req);

  assert_base_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_addr) == RA_VBASE) |-> (reg_rdata[DATA_W-1:BASE_W] == '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_lvl(core_lvl), .irq_req(irq_req),
  .irq_lvl(irq_lvl), .irq_vec(irq_vec), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .take(take), .last_vec(last_vec)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 82;
  localparam int NPRIO = (NV + 7) / 8;
  localparam int NPEND = (NV - 2 + 15) / 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NV-1:0]  src_req = '0;
  logic [2:0]     core_lvl = '0;
  logic           irq_ack = 1'b0;
  logic [5:0]     reg_addr = '0;
  logic           reg_wr = 1'b0;
  logic [15:0]    reg_wdata = '0;
  logic [15:0]    reg_rdata;
  logic           irq_req;
  logic [2:0]     irq_lvl;
  logic [6:0]     irq_vec;
  logic [20:0]    irq_addr;

  irq_prio_ctrl #(.NUM_VEC(NV)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [1:0]    prio_m [NV];
  logic [NV-1:0] pend_m = '0;
  logic [12:0]   base_m = '0;
  int            fv_m [2];
  logic [20:0]   fa_m [2];
  int            last_m = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [15:0] d);
    @(negedge clk); reg_addr = 6'(a); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    if (a < NPRIO)
      for (int j = 0; j < 8; j++)
        if (a*8+j >= 10 && a*8+j < NV) prio_m[a*8+j] = d[2*j +: 2];
    case (a)
      'h10: base_m = d[12:0];
      'h11: fv_m[0] = int'(d[6:0]);
      'h12: fa_m[0][20:16] = d[4:0];
      'h13: fa_m[0][15:0] = d;
      'h14: fv_m[1] = int'(d[6:0]);
      'h15: fa_m[1][20:16] = d[4:0];
      'h16: fa_m[1][15:0] = d;
      default: ;
    endcase
  endtask

  task automatic rreg(input int a, output logic [15:0] d);
    @(negedge clk); reg_addr = 6'(a);
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [15:0] pend_word(input int k);
    logic [15:0] w = '0;
    for (int i = 0; i < 16; i++)
      if (2+16*k+i < NV) w[i] = pend_m[2+16*k+i];
    return w;
  endfunction

  // expected winner, written from the requirements
  task automatic model_win(output bit f, output int vec, output int rank, output int fb);
    int floor_v;
    floor_v = (core_lvl > 3'd4) ? 4 : int'(core_lvl);
    f = 0; vec = 0; rank = 0; fb = 0;
    for (int v = 2; v < NV; v++) begin
      int r; int b; bit en;
      b = 0;
      if (v < 10) begin en = 1; r = (v <= 5) ? 4 : 9 - v; end
      else begin
        en = (prio_m[v] != 2'b00); r = int'(prio_m[v]);
        if (en && v == fv_m[0]) begin r = 3; b = 2; end
        else if (en && v == fv_m[1]) begin r = 3; b = 1; end
      end
      if (pend_m[v] && en && r >= floor_v && (!f || r > rank || (r == rank && b > fb))) begin
        f = 1; vec = v; rank = r; fb = b;
      end
    end
  endtask

  task automatic check_out(input string tag);
    bit f; int v, r, b; logic [20:0] ea;
    model_win(f, v, r, b);
    chk({tag, " irq_req"}, 32'(irq_req), 32'(f));
    if (f) begin
      ea = (b == 2) ? fa_m[0] : (b == 1) ? fa_m[1] : 21'({base_m, 8'h00}) + 21'(2*v);
      chk({tag, " irq_vec"}, 32'(irq_vec), 32'(v));
      chk({tag, " irq_lvl"}, 32'(irq_lvl), 32'(r + 1));
      chk({tag, " irq_addr R6"}, 32'(irq_addr), 32'(ea));
    end
  endtask

  task automatic drive(input logic [NV-1:0] r, input logic [2:0] c);
    @(negedge clk);
    src_req = r & ~NV'(3);
    core_lvl = c;
    pend_m = pend_m | src_req;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_ack(input bit drop);
    int v;
    v = int'(irq_vec);
    @(negedge clk); irq_ack = 1'b1; if (drop) src_req = '0;
    @(negedge clk); irq_ack = 1'b0;
    chk("R7 irq_req low after ack", 32'(irq_req), 0);
    last_m = v;
    if (!src_req[v]) pend_m[v] = 1'b0;
  endtask

  task automatic flush();
    logic [15:0] d;
    for (int k = 0; k < NPRIO; k++) wreg(k, 16'hFFFF);
    drive('0, 3'd0);
    for (int i = 0; i < 200; i++) begin
      if (!irq_req) break;
      do_ack(1'b0);
      @(negedge clk);
    end
    for (int k = 0; k < NPEND; k++) begin
      rreg('h20 + k, d);
      chk("R8 pending after drain", 32'(d), 32'(pend_word(k)));
    end
  endtask

  function automatic logic [NV-1:0] vbits(input int a, input int b, input int c);
    logic [NV-1:0] r = '0;
    if (a >= 0) r[a] = 1'b1;
    if (b >= 0) r[b] = 1'b1;
    if (c >= 0) r[c] = 1'b1;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [NV-1:0] r;
    void'($urandom(32'd4242));
    for (int v = 0; v < NV; v++) prio_m[v] = 2'b00;
    fv_m[0] = 0; fv_m[1] = 0; fa_m[0] = '0; fa_m[1] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R6 reset irq_req", 32'(irq_req), 0);
    rreg(5, d);    chk("R1 reset priority disabled", 32'(d), 0);
    rreg('h20, d); chk("R8 reset pending clear", 32'(d), 0);
    rreg('h18, d); chk("R7 reset last vector", 32'(d), 0);

    // base register reserved bits
    wreg('h10, 16'hFFFF); rreg('h10, d);
    chk("R9 base reserved bits", 32'(d), 32'h1FFF);
    wreg('h10, 16'h0123);

    // fixed fields ignore writes
    wreg(0, 16'hFFFF); rreg(0, d); chk("R1 fixed fields reg0", 32'(d), 0);
    wreg(1, 16'hFFFF); rreg(1, d); chk("R1 mixed fields reg1", 32'(d), 32'hFFF0);
    wreg(1, 16'h0000);

    // acceptance and fixed levels
    wreg(2, 16'h0300);   // vector 20 at level 2
    drive(vbits(20, 6, -1), 3'd4);
    chk("R3 level-2 blocked at core level 2", 32'(irq_req), 0);
    check_out("R3 blocked");
    drive(vbits(20, 6, -1), 3'd2);
    chk("R4 lowest vector at level 2", 32'(irq_vec), 6);
    check_out("R4 tie");
    drive(vbits(20, 6, 4), 3'd5);
    chk("R2 level-3 exception accepted", 32'(irq_vec), 4);
    chk("R2 level code of exception", 32'(irq_lvl), 5);
    chk("R6 table address", 32'(irq_addr), 32'h12308);
    flush();

    // fast slots
    drive(vbits(20, 30, -1), 3'd2);
    chk("R4 plain level-2 lowest", 32'(irq_vec), 20);
    wreg('h14, 16'd30); wreg('h15, 16'h0001); wreg('h16, 16'hABCD);
    repeat (2) @(negedge clk);
    chk("R5 fast slot 1 promoted", 32'(irq_vec), 30);
    chk("R5 fast slot 1 address", 32'(irq_addr), 32'h1ABCD);
    wreg('h11, 16'd20); wreg('h12, 16'h0000); wreg('h13, 16'h0042);
    repeat (2) @(negedge clk);
    chk("R5 fast slot 0 beats slot 1", 32'(irq_vec), 20);
    chk("R5 fast slot 0 address", 32'(irq_addr), 32'h00042);
    rreg('h13, d); chk("R10 fast slot low readback", 32'(d), 32'h0042);
    rreg('h15, d); chk("R10 fast slot high readback", 32'(d), 32'h0001);
    do_ack(1'b0);
    rreg('h18, d); chk("R7 last vector after ack", 32'(d), 20);
    rreg('h21, d); chk("R8 held request stays pending", 32'(d[2]), 1);
    wreg('h11, 16'd0); wreg('h14, 16'd0);
    flush();

    // equal level-1 requests, then blocked by core level 1
    wreg(1, 16'h0200); wreg(6, 16'h0020);
    drive(vbits(50, 12, 7), 3'd0);
    chk("R4 lowest of level-1 group", 32'(irq_vec), 7);
    check_out("R4 level-1 group");
    drive(vbits(50, 12, -1), 3'd3);
    chk("R3 level-1 blocked at core level 1", 32'(irq_req), 0);
    flush();

    // constrained random
    for (int it = 0; it < 300; it++) begin
      if ($urandom % 8 == 0) flush();
      repeat (2) wreg(1 + int'($urandom % (NPRIO - 1)), 16'($urandom));
      if ($urandom % 4 == 0) begin
        int s;
        s = int'($urandom % 2);
        wreg('h11 + 3*s, ($urandom % 3 == 0) ? 16'd0 : 16'(10 + $urandom % (NV - 10)));
        wreg('h12 + 3*s, 16'($urandom));
        wreg('h13 + 3*s, 16'($urandom));
      end
      if ($urandom % 6 == 0) wreg('h10, 16'($urandom));
      r = '0;
      for (int v = 2; v < NV; v++) r[v] = ($urandom % 10 == 0);
      drive(r, 3'($urandom % 6));
      check_out("R3 R4 R5 random");
      if (irq_req && ($urandom % 2 == 0)) begin
        do_ack(1'($urandom % 2));
        @(negedge clk);
        check_out("R8 after ack");
      end
      rreg('h18, d);
      chk("R7 last vector", 32'(d), 32'(last_m));
      if ($urandom % 4 == 0) begin
        int k;
        k = int'($urandom % NPEND);
        rreg('h20 + k, d);
        chk("R8 pending bitmap", 32'(d), 32'(pend_word(k)));
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule